// File: doc/BRIEF.md
# Serial EEPROM Word Reader

This block is a hardware master that fetches one 16-bit word from a three-wire serial EEPROM of the small (64-word) or large (256-word) class. A single-cycle start request, together with a word address and a device-size select, launches one read frame. The block drives the memory's chip select, serial clock and serial data input, and it samples the memory's serial data output. When the frame ends it presents the assembled word and raises a one-cycle done pulse.

Each frame follows a fixed sequence. Chip select rises, and one framing clock follows. The block then sends the read opcode and the address, and holds data-in low while it issues sixteen capture clocks. Chip select then falls and one more framing clock follows. Every pin change is followed by a settle interval. Every clock half-period and every settle interval lasts `DIVIDER` system clocks, so the serial rate is set at build time.

Top module: `mw_eeprom_reader`

## Requirements
- R1: After reset, and whenever the block is idle, `eep_cs_o`, `eep_sk_o`, `eep_di_o`, `busy_o` and `done_o` are low. After reset `data_o` is zero.
- R2: While idle, a high `start_i` is accepted on a clock edge. `busy_o` is high from the next cycle until the done pulse. The address and size select are captured at acceptance. A `start_i` that arrives while busy is ignored and does not change the frame in progress or its result.
- R3: A frame opens with chip select rising. One full serial clock cycle (high, then low) follows with data-in low, before any command bit is sent.
- R4: The command is the opcode bits 1, 1, 0, then the address MSB first. The address is `addr_i[5:0]` (6 bits) when `wide_i`=0 and `addr_i[7:0]` (8 bits) when `wide_i`=1. The memory sees one bit per serial clock rising edge.
- R5: Data-in changes only while the serial clock is low. It never changes in the same system cycle as a serial clock edge, so each bit is held through its full clock cycle.
- R6: After the address, data-in stays low for the rest of the frame. Sixteen serial clock cycles follow. The data-out pin is sampled at the end of each low phase and shifted in MSB first, so the first bit captured becomes bit 15 of the result.
- R7: After the last capture, chip select falls while the serial clock is low. Exactly one more serial clock cycle follows with chip select low, and then the frame ends.
- R8: Each pin state lasts `DIVIDER` system clocks. From the accepting edge to the edge that raises `done_o` there are `DIVIDER*(48+3*L)` cycles, where L is the address length (66 steps for the small device, 72 for the large).
- R9: `done_o` is a one-cycle pulse during which `busy_o` is already low. `data_o` takes the new word on the same edge as the done pulse and holds it until the next frame completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Request to read one word |
| addr_i | input | 8 | Word address (only the low 6 bits are used when `wide_i`=0) |
| wide_i | input | 1 | Device size select: 0 = 6-bit address, 1 = 8-bit address |
| eep_do_i | input | 1 | Serial data from the memory |
| eep_cs_o | output | 1 | Memory chip select, active high |
| eep_sk_o | output | 1 | Serial clock to the memory |
| eep_di_o | output | 1 | Serial data to the memory |
| busy_o | output | 1 | Frame in progress |
| done_o | output | 1 | One-cycle pulse when the word is ready |
| data_o | output | 16 | Last word read |

## Verification
The hardest case to reach from the ports is a start request that arrives in the middle of a frame carrying a different address and size. It must leave no mark on the wire sequence or on the result. The bench pulses `start_i` with an inverted address and the opposite size select partway through selected frames. A bus-functional memory model rebuilds the command it received from the pin edges, and the bench compares that command, the clock counts and the frame length against the first request. The bench sweeps every address of both device sizes, and each memory word is a value computed arithmetically from its address.

// File: rtl/mw_pkg.sv
// Package: shared state encoding for the serial EEPROM word reader.
// Assumes: one frame state per pin configuration; each state lasts one step.
package mw_pkg;
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CS_ON,
        ST_PRE_HI,
        ST_PRE_LO,
        ST_TX_SET,
        ST_TX_HI,
        ST_TX_LO,
        ST_DI_LOW,
        ST_RX_HI,
        ST_RX_LO,
        ST_CS_OFF,
        ST_POST_HI,
        ST_POST_LO
    } mw_state_t;

    localparam logic [2:0] MW_READ_OP = 3'b110;
endpackage

// File: rtl/mw_step_timer.sv
// Module: step timer. Emits one tick every DIV system clocks while run is high.
// Assumes: DIV >= 1; the count restarts from zero whenever run is low.
module mw_step_timer #(
    parameter int DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt;

    // Purpose: count system clocks within the current step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run || cnt == LAST) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign tick = run && (cnt == LAST);

    assert_count_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST);
    assert_idle_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> cnt == '0);
endmodule

// File: rtl/mw_frame_fsm.sv
// Module: frame sequencer. Drives chip select, serial clock and data-in
// through open clock, command, capture and close clock phases.
// Assumes: tick marks the last system clock of each step; start is ignored unless idle.
module mw_frame_fsm
    import mw_pkg::*;
#(
    parameter int AW_BIG   = 8,
    parameter int AW_SMALL = 6,
    parameter int DW       = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [AW_BIG-1:0] addr,
    input  logic              wide,
    input  logic              tick,
    output logic              cs,
    output logic              sk,
    output logic              di,
    output logic              busy,
    output logic              sample,
    output logic              finish
);
    localparam int HW   = 3 + AW_BIG;
    localparam int MAXN = (HW > DW) ? HW : DW;
    localparam int CW   = $clog2(MAXN + 1);
    localparam int PADW = AW_BIG - AW_SMALL;

    mw_state_t         state;
    logic [HW-1:0]     txsr;
    logic [CW-1:0]     nbits;
    logic [CW-1:0]     cnt;

    // Purpose: advance the frame one step per tick and shift the command out.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            txsr  <= '0;
            nbits <= '0;
            cnt   <= '0;
        end else if (state == ST_IDLE) begin
            if (start) begin
                state <= ST_CS_ON;
                cnt   <= '0;
                if (wide) begin
                    txsr  <= {MW_READ_OP, addr};
                    nbits <= CW'(HW);
                end else begin
                    txsr  <= {MW_READ_OP, addr[AW_SMALL-1:0], {PADW{1'b0}}};
                    nbits <= CW'(3 + AW_SMALL);
                end
            end
        end else if (tick) begin
            case (state)
                ST_CS_ON:   state <= ST_PRE_HI;
                ST_PRE_HI:  state <= ST_PRE_LO;
                ST_PRE_LO:  state <= ST_TX_SET;
                ST_TX_SET:  state <= ST_TX_HI;
                ST_TX_HI:   state <= ST_TX_LO;
                ST_TX_LO: begin
                    txsr <= {txsr[HW-2:0], 1'b0};
                    if (cnt == nbits - 1'b1) begin
                        cnt   <= '0;
                        state <= ST_DI_LOW;
                    end else begin
                        cnt   <= cnt + 1'b1;
                        state <= ST_TX_SET;
                    end
                end
                ST_DI_LOW:  state <= ST_RX_HI;
                ST_RX_HI:   state <= ST_RX_LO;
                ST_RX_LO: begin
                    if (cnt == CW'(DW - 1)) begin
                        cnt   <= '0;
                        state <= ST_CS_OFF;
                    end else begin
                        cnt   <= cnt + 1'b1;
                        state <= ST_RX_HI;
                    end
                end
                ST_CS_OFF:  state <= ST_POST_HI;
                ST_POST_HI: state <= ST_POST_LO;
                default:    state <= ST_IDLE;
            endcase
        end
    end

    // Purpose: decode the pin levels and the per-step strobes from the state.
    always_comb begin
        cs     = (state != ST_IDLE) && (state != ST_CS_OFF) &&
                 (state != ST_POST_HI) && (state != ST_POST_LO);
        sk     = (state == ST_PRE_HI) || (state == ST_TX_HI) ||
                 (state == ST_RX_HI) || (state == ST_POST_HI);
        di     = ((state == ST_TX_SET) || (state == ST_TX_HI) ||
                  (state == ST_TX_LO)) && txsr[HW-1];
        busy   = (state != ST_IDLE);
        sample = tick && (state == ST_RX_LO);
        finish = tick && (state == ST_POST_LO);
    end

    assert_quiet_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !cs && !sk && !di);
    assert_length_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        busy && $past(busy) |-> $stable(nbits));
    assert_di_edge_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sk) |-> $stable(di));
    assert_di_high_phase_R5: assert property (@(posedge clk) disable iff (!rst_n)
        sk && $past(sk) |-> $stable(di));
    assert_sample_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        sample |-> cs && !sk && !di);
    assert_cs_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs) |-> !sk);
endmodule

// File: rtl/mw_rx_capture.sv
// Module: capture shifter. Shifts the data-out pin in MSB first on each
// sample strobe and publishes the word with a done pulse at frame end.
// Assumes: exactly DW samples per frame; load arrives after the last sample.
module mw_rx_capture #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sample,
    input  logic          din,
    input  logic          load,
    output logic [DW-1:0] result,
    output logic          done
);
    logic [DW-1:0] sr;

    // Purpose: shift in serial data and publish the word at frame end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr     <= '0;
            result <= '0;
            done   <= 1'b0;
        end else begin
            if (sample) begin
                sr <= {sr[DW-2:0], din};
            end
            if (load) begin
                result <= sr;
            end
            done <= load;
        end
    end

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_result_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(result));
endmodule

// File: rtl/mw_eeprom_reader.sv
// Module: top of the serial EEPROM word reader: step timer, frame sequencer
// and capture shifter.
// Assumes: DIVIDER below 1 is treated as 1; the memory updates data-out after
// each serial clock rising edge.
module mw_eeprom_reader #(
    parameter int DIVIDER = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start_i,
    input  logic [7:0]  addr_i,
    input  logic        wide_i,
    input  logic        eep_do_i,
    output logic        eep_cs_o,
    output logic        eep_sk_o,
    output logic        eep_di_o,
    output logic        busy_o,
    output logic        done_o,
    output logic [15:0] data_o
);
    localparam int DIV_EFF = (DIVIDER < 1) ? 1 : DIVIDER;

    logic tick;
    logic sample;
    logic finish;

    mw_step_timer #(.DIV(DIV_EFF)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (busy_o),
        .tick  (tick)
    );

    mw_frame_fsm #(.AW_BIG(8), .AW_SMALL(6), .DW(16)) u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start_i),
        .addr   (addr_i),
        .wide   (wide_i),
        .tick   (tick),
        .cs     (eep_cs_o),
        .sk     (eep_sk_o),
        .di     (eep_di_o),
        .busy   (busy_o),
        .sample (sample),
        .finish (finish)
    );

    mw_rx_capture #(.DW(16)) u_cap (
        .clk    (clk),
        .rst_n  (rst_n),
        .sample (sample),
        .din    (eep_do_i),
        .load   (finish),
        .result (data_o),
        .done   (done_o)
    );

    assert_done_not_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);
    assert_start_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        start_i && !busy_o |=> busy_o);
endmodule

// File: tb/mw_eeprom_reader_tb.sv
module mw_eeprom_reader_tb;
    localparam int DIV = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [7:0]  addr_i = '0;
    logic        wide_i = 1'b0;
    logic        eep_do_i = 1'b0;
    logic        eep_cs_o, eep_sk_o, eep_di_o, busy_o, done_o;
    logic [15:0] data_o;

    int total = 0;
    int bad = 0;
    int cycles = 0;

    always #10 clk = ~clk;
    always @(posedge clk) cycles <= cycles + 1;

    mw_eeprom_reader #(.DIVIDER(DIV)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .addr_i(addr_i),
        .wide_i(wide_i), .eep_do_i(eep_do_i), .eep_cs_o(eep_cs_o),
        .eep_sk_o(eep_sk_o), .eep_di_o(eep_di_o), .busy_o(busy_o),
        .done_o(done_o), .data_o(data_o)
    );

    function automatic logic [15:0] mem_word(input int a, input logic big);
        logic [15:0] w;
        w = 16'(a * 40503);
        w = w ^ 16'hA5C3 ^ {big, 15'b0};
        return w;
    endfunction

    // memory model state
    int          cur_addr = 0;
    logic        cur_big = 1'b0;
    logic        psk = 1'b0, pcs = 1'b0, pdi = 1'b0;
    int          rises = 0, post_rises = 0, hdr = 0, ridx = 0;
    int          err_di = 0, err_edge = 0, err_pre = 0;

    // Bus-functional memory, sampled away from the active edge.
    always @(negedge clk) begin
        int alen;
        alen = cur_big ? 8 : 6;
        if (eep_cs_o && !pcs) begin
            rises = 0; post_rises = 0; hdr = 0; ridx = 0;
            err_di = 0; err_edge = 0; err_pre = 0;
        end
        if ((eep_sk_o != psk) && (eep_di_o != pdi)) err_edge++;
        if (eep_sk_o && psk && (eep_di_o != pdi)) err_edge++;
        if (eep_sk_o && !psk) begin
            if (eep_cs_o) begin
                if (rises == 0) begin
                    if (eep_di_o) err_pre++;
                end else if (rises <= 3 + alen) begin
                    hdr = (hdr << 1) | int'(eep_di_o);
                end else begin
                    if (eep_di_o) err_di++;
                    if (ridx < 16) eep_do_i <= mem_word(cur_addr, cur_big)[15 - ridx];
                    ridx++;
                end
                rises++;
            end else begin
                post_rises++;
            end
        end
        psk = eep_sk_o; pcs = eep_cs_o; pdi = eep_di_o;
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic run_txn(input int a, input logic big, input logic inject);
        int n;
        int alen;
        logic [15:0] prev;
        alen = big ? 8 : 6;
        prev = data_o;
        @(negedge clk);
        chk("R9", "result held before start", int'(data_o), int'(prev));
        cur_addr = big ? (a & 255) : (a & 63);
        cur_big = big;
        addr_i = 8'(a);
        wide_i = big;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk("R2", "busy after accept", int'(busy_o), 1);
        n = 1;
        while (!done_o && n < 2000) begin
            if (inject && n == 60) begin
                addr_i = ~addr_i;
                wide_i = ~big;
                start_i = 1'b1;
            end else begin
                start_i = 1'b0;
            end
            @(negedge clk);
            n++;
        end
        start_i = 1'b0;
        if (n >= 2000) chk("R8", "watchdog frame", 0, 1);
        chk("R8", "frame length", n - 1, DIV * (48 + 3 * alen));
        chk("R9", "busy low at done", int'(busy_o), 0);
        chk("R6", "read word", int'(data_o), int'(mem_word(cur_addr, big)));
        chk("R4", "command bits", hdr, (6 << alen) | cur_addr);
        chk("R3", "open clock data low", err_pre, 0);
        chk("R6", "clock count in frame", rises, 1 + 3 + alen + 16);
        chk("R6", "data-in low while reading", err_di, 0);
        chk("R5", "data-in edge rule", err_edge, 0);
        chk("R7", "close clock count", post_rises, 1);
        @(negedge clk);
        chk("R9", "done single pulse", int'(done_o), 0);
        chk("R1", "idle pins", int'({eep_cs_o, eep_sk_o, eep_di_o, busy_o}), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "reset pins", int'({eep_cs_o, eep_sk_o, eep_di_o, busy_o, done_o}), 0);
        chk("R1", "reset result", int'(data_o), 0);
        for (int a = 0; a < 64; a++) run_txn(a, 1'b0, (a % 9) == 4);
        for (int a = 0; a < 256; a++) run_txn(a, 1'b1, (a % 17) == 3);
        run_txn(255, 1'b0, 1'b0);
        repeat (5) @(negedge clk);
        chk("R9", "result held when idle", int'(data_o), int'(mem_word(63, 1'b0)));
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        wait (cycles > 190000);
        total++;
        bad++;
        $display("FAIL watchdog R8 actual=%0d expected=%0d", cycles, 190000);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule